// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent down-counters of `CNT_W` bits that step once per clock while enabled. Each channel is either periodic, reloading itself from its own reload register after it passes zero, or one-shot, where a value loaded by software counts down once, raises one event and then parks at zero. Software loads, starts, stops and reads back each counter through a register port with single-cycle access. A free-running channel loaded with all ones lets software measure elapsed ticks as all ones minus the value read.

Each expiry sets a sticky cause bit for its channel. A per-channel mask bit decides whether that cause bit drives the shared interrupt line. Software acknowledges a cause bit by writing zero to it.

Byte offsets, with `N_TIMERS = 2`: control `0x00`, cause `0x04`, mask `0x08`, channel 0 reload `0x10`, channel 0 value `0x14`, channel 1 reload `0x18`, channel 1 value `0x1C`. Each further channel adds 8 to both of its offsets.

Top module: `dual_timer`

## Requirements
- R1: After reset the control, cause and mask registers, both counters and both reload registers read zero, and `irq_o` is low.
- R2: The control register at 0x00 holds, for channel i, a run bit at bit 2i and a periodic bit at bit 2i+1, and reads back the value written.
- R3: While its run bit is set and its count is not zero, a counter drops by one on every clock, and a read of its value register returns the live count.
- R4: While its run bit is clear, a counter holds its value.
- R5: In periodic mode, with the reload register at N-1, the channel expires once every N clocks: an expiry happens on a clock where the count is zero, and the count then takes the reload value.
- R6: In one-shot mode a channel expires once when its count reaches zero, then stays at zero and raises no further event until software writes its value register again.
- R7: A write to a value register (0x14, 0x1C) loads that counter on the next clock whether or not the channel runs, and it takes priority over counting and reloading.
- R8: An expiry sets cause bit i (register 0x04, bit i) whether or not the channel is masked.
- R9: A write to 0x04 clears each cause bit written as 0 and leaves each bit written as 1 unchanged. An expiry in the same clock as a clearing write leaves the bit set.
- R10: `irq_o` is high exactly when some cause bit and the mask bit at the same position (register 0x08, bit i) are both set.
- R11: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counters step on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, valid in the same cycle |
| irq_o | output | 1 | Interrupt: OR over the masked cause bits |

## Verification
The assertions assume that `bus_addr` and `bus_wr` are stable and known whenever `bus_sel` is high. They also assume that software never writes a value register and expects the old count to keep stepping in the same clock. The bench drives every access from a negative clock edge and holds it for a full cycle. It keeps value and reload writes small, so that expiries, one-shot parking and same-cycle clear-and-expire collisions occur often within a short random run.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_CAUSE  = 4;
  localparam int OFS_MASK   = 8;
  localparam int OFS_CH0    = 16;
  localparam int OFS_STRIDE = 8;
  localparam int OFS_VALUE  = 4;

  function automatic int reload_ofs(input int ch);
    return OFS_CH0 + OFS_STRIDE * ch;
  endfunction

  function automatic int value_ofs(input int ch);
    return OFS_CH0 + OFS_STRIDE * ch + OFS_VALUE;
  endfunction
endpackage

// File: rtl/dtmr_rst_sync.sv
module dtmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             periodic_i,
  input  logic             ld_reload_i,
  input  logic             ld_value_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rel_q;
  logic             armed_q, armed_d;
  logic             at_zero, expire, cnt_en, armed_en;

  // next-state
  always_comb begin
    at_zero  = (cnt_q == '0);
    expire   = run_i && at_zero && (periodic_i || armed_q);
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    if (ld_value_i) begin
      cnt_d  = wdata_i;
      cnt_en = 1'b1;
    end else if (expire && periodic_i) begin
      cnt_d  = rel_q;
      cnt_en = 1'b1;
    end else if (run_i && !at_zero) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
    armed_en = ld_value_i || (expire && !periodic_i);
    armed_d  = ld_value_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rel_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_en)      cnt_q   <= cnt_d;
      if (ld_reload_i) rel_q   <= wdata_i;
      if (armed_en)    armed_q <= armed_d;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rel_q;
  assign expire_o = expire;
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
  parameter int N_TIMERS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_cause_i,
  input  logic                wr_mask_i,
  input  logic [N_TIMERS-1:0] wdata_i,
  input  logic [N_TIMERS-1:0] expire_i,
  output logic [N_TIMERS-1:0] cause_o,
  output logic [N_TIMERS-1:0] mask_o,
  output logic                irq_o
);
  logic [N_TIMERS-1:0] cause_q, cause_d, mask_q;
  logic                cause_en;

  always_comb begin
    cause_d  = (wr_cause_i ? (cause_q & wdata_i) : cause_q) | expire_i;
    cause_en = wr_cause_i || (|expire_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      if (cause_en)  cause_q <= cause_d;
      if (wr_mask_i) mask_q  <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(cause_q & mask_q);
endmodule

// File: rtl/dtmr_regif.sv
module dtmr_regif
  import dtmr_pkg::*;
#(
  parameter int N_TIMERS = 2,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8,
  localparam int CTRL_W  = 2 * N_TIMERS
) (
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [CTRL_W-1:0]              ctrl_i,
  input  logic [N_TIMERS-1:0]            cause_i,
  input  logic [N_TIMERS-1:0]            mask_i,
  input  logic [N_TIMERS-1:0][CNT_W-1:0] count_i,
  input  logic [N_TIMERS-1:0][CNT_W-1:0] reload_i,
  output logic                           wr_ctrl_o,
  output logic                           wr_cause_o,
  output logic                           wr_mask_o,
  output logic [N_TIMERS-1:0]            wr_reload_o,
  output logic [N_TIMERS-1:0]            wr_value_o,
  output logic [CNT_W-1:0]               rdata_o
);
  logic wr_any;
  assign wr_any     = bus_sel && bus_wr;
  assign wr_ctrl_o  = wr_any && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_cause_o = wr_any && (bus_addr == ADDR_W'(OFS_CAUSE));
  assign wr_mask_o  = wr_any && (bus_addr == ADDR_W'(OFS_MASK));

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_dec
    assign wr_reload_o[g] = wr_any && (bus_addr == ADDR_W'(reload_ofs(g)));
    assign wr_value_o[g]  = wr_any && (bus_addr == ADDR_W'(value_ofs(g)));
  end

  always_comb begin
    rdata_o = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL))  rdata_o[CTRL_W-1:0]   = ctrl_i;
    if (bus_addr == ADDR_W'(OFS_CAUSE)) rdata_o[N_TIMERS-1:0] = cause_i;
    if (bus_addr == ADDR_W'(OFS_MASK))  rdata_o[N_TIMERS-1:0] = mask_i;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (bus_addr == ADDR_W'(reload_ofs(i))) rdata_o = reload_i[i];
      if (bus_addr == ADDR_W'(value_ofs(i)))  rdata_o = count_i[i];
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int N_TIMERS = 2,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  localparam int CTRL_W = 2 * N_TIMERS;

  logic                           rst_sync_n;
  logic [CTRL_W-1:0]              ctrl_q, ctrl_d;
  logic [N_TIMERS-1:0]            cause_q, mask_q, expire_vec;
  logic [N_TIMERS-1:0]            wr_reload, wr_value;
  logic [N_TIMERS-1:0][CNT_W-1:0] count_vec, reload_vec;
  logic                           wr_ctrl, wr_cause, wr_mask;

  dtmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dtmr_regif #(
    .N_TIMERS (N_TIMERS),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W)
  ) u_regif (
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .ctrl_i      (ctrl_q),
    .cause_i     (cause_q),
    .mask_i      (mask_q),
    .count_i     (count_vec),
    .reload_i    (reload_vec),
    .wr_ctrl_o   (wr_ctrl),
    .wr_cause_o  (wr_cause),
    .wr_mask_o   (wr_mask),
    .wr_reload_o (wr_reload),
    .wr_value_o  (wr_value),
    .rdata_o     (bus_rdata)
  );

  // control register: next-state and register
  always_comb ctrl_d = bus_wdata[CTRL_W-1:0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_ch
    dtmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .run_i       (ctrl_q[2*g]),
      .periodic_i  (ctrl_q[2*g+1]),
      .ld_reload_i (wr_reload[g]),
      .ld_value_i  (wr_value[g]),
      .wdata_i     (bus_wdata),
      .count_o     (count_vec[g]),
      .reload_o    (reload_vec[g]),
      .expire_o    (expire_vec[g])
    );
  end

  dtmr_irq #(.N_TIMERS(N_TIMERS)) u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_cause_i (wr_cause),
    .wr_mask_i  (wr_mask),
    .wdata_i    (bus_wdata[N_TIMERS-1:0]),
    .expire_i   (expire_vec),
    .cause_o    (cause_q),
    .mask_o     (mask_q),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dtmr_pkg::*;
#(
  parameter int N_TIMERS = 2,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_sel,
  input logic                           bus_wr,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [CNT_W-1:0]               bus_wdata,
  input logic [2*N_TIMERS-1:0]          ctrl_q,
  input logic [N_TIMERS-1:0]            cause_q,
  input logic [N_TIMERS-1:0]            mask_q,
  input logic [N_TIMERS-1:0][CNT_W-1:0] count_vec,
  input logic                           irq_o
);
  logic cause_wr;
  assign cause_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CAUSE));

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o); // R10

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_ast
    logic val_wr;
    assign val_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(value_ofs(g)));

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[2*g] && count_vec[g] != '0 && !val_wr)
      |=> (count_vec[g] == $past(count_vec[g]) - 1'b1)); // R3

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[2*g] && !val_wr) |=> $stable(count_vec[g])); // R4

    AST_PERIODIC_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[2*g] && ctrl_q[2*g+1] && count_vec[g] == '0) |=> cause_q[g]); // R5

    AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[2*g] && !ctrl_q[2*g+1] && count_vec[g] == '0 && !val_wr)
      |=> (count_vec[g] == '0)); // R6

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q[g] && !(cause_wr && !bus_wdata[g])) |=> cause_q[g]); // R9
  end
endmodule

bind dual_timer dual_timer_chk #(
  .N_TIMERS (N_TIMERS),
  .CNT_W    (CNT_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ctrl_q    (ctrl_q),
  .cause_q   (cause_q),
  .mask_q    (mask_q),
  .count_vec (count_vec),
  .irq_o     (irq_o)
);

// File: tb/dual_timer_bench.sv
module dual_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [3:0]  m_ctrl = '0;
  logic [1:0]  m_cause = '0, m_mask = '0;
  logic [31:0] m_cnt[2] = '{default: '0};
  logic [31:0] m_rel[2] = '{default: '0};
  bit          m_arm[2] = '{default: 0};
  int          ev[2] = '{default: 0};

  always #5 clk = ~clk;

  dual_timer u_dual_timer (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .irq_o (irq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return {28'd0, m_ctrl};
      8'h04: return {30'd0, m_cause};
      8'h08: return {30'd0, m_mask};
      8'h10: return m_rel[0];
      8'h14: return m_cnt[0];
      8'h18: return m_rel[1];
      8'h1C: return m_cnt[1];
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step(input bit sel, input bit wr, input logic [7:0] a, input logic [31:0] d);
    bit [1:0] ex;
    bit w = sel && wr;
    for (int i = 0; i < 2; i++)
      ex[i] = m_ctrl[2*i] && (m_cnt[i] == 0) && (m_ctrl[2*i+1] || m_arm[i]);
    for (int i = 0; i < 2; i++) begin
      if (w && a == 8'(8'h14 + 8*i)) begin
        m_cnt[i] = d;
        m_arm[i] = 1;
      end else begin
        if (ex[i] && m_ctrl[2*i+1]) m_cnt[i] = m_rel[i];
        else if (m_ctrl[2*i] && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
        if (ex[i] && !m_ctrl[2*i+1]) m_arm[i] = 0;
      end
      if (w && a == 8'(8'h10 + 8*i)) m_rel[i] = d;
      ev[i] += int'(ex[i]);
    end
    m_cause = ((w && a == 8'h04) ? (m_cause & d[1:0]) : m_cause) | ex;
    if (w && a == 8'h08) m_mask = d[1:0];
    if (w && a == 8'h00) m_ctrl = d[3:0];
  endtask

  // one bus cycle, entered and left at a negative edge
  task automatic cyc(input bit sel, input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input string tag, output logic [31:0] rd);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    rd = bus_rdata;
    if (sel && !wr) chk(bus_rdata === model_read(a), tag, bus_rdata, model_read(a));
    chk(irq_o === |(m_cause & m_mask), "R10 irq", {31'd0, irq_o}, {31'd0, |(m_cause & m_mask)});
    @(posedge clk);
    model_step(sel, wr, a, d);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    cyc(1, 1, a, d, "write", r);
  endtask

  task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] r);
    cyc(1, 0, a, 32'd0, tag, r);
  endtask

  task automatic idle(input int n);
    logic [31:0] r;
    for (int k = 0; k < n; k++) cyc(0, 0, 8'h00, 32'd0, "idle", r);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int base;
    logic [7:0] addrs[8] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h0C};
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state of every register
    foreach (addrs[k]) begin
      rd(addrs[k], "R1 reset read", r);
      chk(r == 32'd0, "R1 reset zero", r, 32'd0);
    end
    chk(irq_o == 1'b0, "R1 irq low", {31'd0, irq_o}, 32'd0);

    // R11: unmapped offsets
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, "R11 unmapped read", r);
    chk(r == 32'd0, "R11 unmapped zero", r, 32'd0);
    rd(8'h00, "R11 ctrl untouched", r);
    rd(8'h08, "R11 mask untouched", r);

    // R2: control layout read-back
    wr(8'h00, 32'hA);
    rd(8'h00, "R2 ctrl readback", r);
    chk(r == 32'hA, "R2 ctrl value", r, 32'hA);
    wr(8'h00, 32'h0);

    // R7 and R4: load while stopped, then hold
    wr(8'h14, 32'd100);
    rd(8'h14, "R7 direct load", r);
    chk(r == 32'd100, "R7 loaded value", r, 32'd100);
    idle(3);
    rd(8'h14, "R4 hold", r);
    chk(r == 32'd100, "R4 held value", r, 32'd100);

    // R3: counting; ctrl write takes effect at its edge, count steps from the next
    wr(8'h00, 32'h1);
    idle(5);
    rd(8'h14, "R3 live count", r);
    chk(r == 32'd95, "R3 count after 5 steps", r, 32'd95);
    wr(8'h00, 32'h0);
    rd(8'h14, "R4 stopped", r);
    idle(4);
    rd(8'h14, "R4 stopped later", r);

    // R5: periodic channel 1 with reload 3 -> one expiry per 4 clocks
    wr(8'h18, 32'd3);
    wr(8'h1C, 32'd3);
    wr(8'h08, 32'h2);
    wr(8'h00, 32'hC);
    base = ev[1];
    idle(40);
    chk(ev[1] - base == 10, "R5 expiry count", 32'(ev[1] - base), 32'd10);
    rd(8'h04, "R5 cause set", r);
    chk(r[1] == 1'b1, "R5 cause bit1", r, 32'h2);

    // R6: one-shot on channel 0
    wr(8'h00, 32'h1);
    wr(8'h04, 32'h0);
    wr(8'h14, 32'd5);
    base = ev[0];
    idle(20);
    chk(ev[0] - base == 1, "R6 single expiry", 32'(ev[0] - base), 32'd1);
    rd(8'h14, "R6 parked", r);
    chk(r == 32'd0, "R6 parked at zero", r, 32'd0);
    rd(8'h04, "R6 cause", r);
    chk(r[0] == 1'b1, "R6 cause bit0", r, 32'h1);
    wr(8'h04, 32'h0);
    idle(10);
    rd(8'h04, "R6 no second event", r);
    chk(r[0] == 1'b0, "R6 stays idle", r, 32'h0);
    wr(8'h14, 32'd2);
    base = ev[0];
    idle(6);
    chk(ev[0] - base == 1, "R6 rearmed", 32'(ev[0] - base), 32'd1);

    // R8 and R10: masked cause still latches; irq follows the mask
    wr(8'h08, 32'h0);
    idle(2);
    rd(8'h04, "R8 masked latch", r);
    chk(r[0] == 1'b1, "R8 cause while masked", r, 32'h1);
    chk(irq_o == 1'b0, "R10 masked irq low", {31'd0, irq_o}, 32'd0);
    wr(8'h08, 32'h1);
    chk(irq_o == 1'b1, "R10 unmasked irq high", {31'd0, irq_o}, 32'd1);

    // R9: clear collides with expiry on channel 1 (expires every clock)
    wr(8'h18, 32'd0);
    wr(8'h1C, 32'd0);
    wr(8'h00, 32'hC);
    wr(8'h04, 32'h0);
    rd(8'h04, "R9 expiry wins", r);
    chk(r == 32'h2, "R9 bit1 kept, bit0 cleared", r, 32'h2);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h3);
    rd(8'h04, "R9 ones keep", r);
    wr(8'h04, 32'h1);
    rd(8'h04, "R9 zero clears", r);
    chk(r == 32'h0, "R9 cleared", r, 32'h0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int pick = $urandom % 10;
      logic [7:0] a = addrs[$urandom % 8];
      logic [31:0] d;
      case (a)
        8'h00:   d = $urandom % 16;
        8'h04, 8'h08: d = $urandom % 4;
        default: d = $urandom % 12;
      endcase
      if (pick < 3)      wr(a, d);
      else if (pick < 6) rd(a, "R3 R5 R6 R8 random read", r);
      else               idle(1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule